// File: doc/BRIEF.md
# Link-Side Transmit Sequencer for a Parallel PHY Interface

This block sits on the link side of a parallel PHY-link interface. The interface has a 2-bit control bus and an 8-bit data bus, both clocked by the PHY system clock. The block watches the PHY's control lines for a grant code followed by an idle code. After that pair it takes over the bus and drives its own tri-state enables. It then streams packet bytes from a ready/valid source. If bytes are late, it covers the wait with one optional idle and a bounded run of hold cycles.

A packet can end in two ways. An idle code ends it and lets the bus go. A hold code ends it and keeps the bus for a concatenated packet. With multispeed concatenation enabled, the hold cycle also carries the next packet's speed code on the upper data bits. After either ending, the block drives exactly one more idle and then tri-states. Speed requests that would put the slowest rate after a faster one are refused and flagged. A source that stalls too long, or leaves a gap inside a packet, makes the block give the bus up and raise an underrun flag.

Top module: `phy_tx_sequencer`

## Requirements
- R1: The enables `ctl_oe`/`data_oe` rise only in the cycle right after `phy_ctl_in` showed grant (11) and then idle (00) in consecutive cycles. A grant followed by any other code does not start a transfer.
- R2: In the first driven cycle with no valid byte, the block drives idle (00). In later waiting cycles it drives hold (01), never a second idle.
- R3: At most `MAX_HOLD` (47) consecutive hold cycles precede transmit.
- R4: A byte is consumed when `src_valid && src_ready`. In that same cycle `ctl_out` is transmit (10) and `data_out` carries the byte. `src_ready` is high only while the block may start or continue a packet.
- R5: The cycle after the last byte (`src_last`) is the terminating cycle. It carries hold (01) when concatenation was requested and accepted, and idle (00) otherwise.
- R6: After the terminating cycle, exactly one idle cycle follows with enables high. In the next cycle the enables are low. While the enables are low, `ctl_out` and `data_out` are zero.
- R7: A hold termination with `ms_enable` set carries `{next_speed, 6'b0}` on `data_out` (00=S100, 01=S200, 10=S400). Without `ms_enable`, `data_out` is zero in that cycle.
- R8: With `ms_enable` set, a concatenation request with `next_speed` = 11, or with S100 after a non-S100 `cur_speed`, pulses `concat_reject` in the last-byte cycle. That packet then terminates with idle.
- R9: If no byte is valid once 47 holds have been driven, the block drives idle with `underrun` high. It then drives the trailing idle and releases the bus.
- R10: A missing byte in the middle of a packet ends it with an idle cycle and `underrun` high, followed by the trailing idle and release.
- R11: During and right after reset, the enables, `src_ready`, both flags and both buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_ctl_in | input | 2 | Control code driven by the PHY (00 idle, 01 status, 10 receive, 11 grant) |
| ctl_out | output | 2 | Control code driven by the link (00 idle, 01 hold, 10 transmit) |
| ctl_oe | output | 1 | Output enable for the control drivers |
| data_out | output | 8 | Data bus value: packet byte or speed code |
| data_oe | output | 1 | Output enable for the data drivers |
| src_data | input | 8 | Packet byte from the source |
| src_valid | input | 1 | Source byte is valid |
| src_last | input | 1 | Source byte is the final one of the packet |
| src_ready | output | 1 | Block accepts a byte this cycle |
| concat_req | input | 1 | End the packet with hold to concatenate (sampled with the last byte) |
| ms_enable | input | 1 | Multispeed concatenation enabled |
| cur_speed | input | 2 | Speed code of the packet being sent |
| next_speed | input | 2 | Speed code of the concatenated packet |
| concat_reject | output | 1 | Concatenation request refused (pulse) |
| underrun | output | 1 | Bus given up because the source had no data (pulse) |

## Verification
Transfers are tried with no wait, with a short lead-in of idle plus holds, and with exactly 47 holds and 48 waiting cycles. These separate a correct hold bound from an off-by-one. Packet lengths of one byte and several bytes show whether transmit can start and end in the same state. The bench sweeps concatenation requests over every speed pair with multispeed on and off. This shows apart a speed code on the bus, a silent hold and a refused request. Mid-packet gaps and a grant followed by a non-idle code cover the abandon paths and the false-start path.

// File: rtl/phy_tx_sequencer.sv
module phy_tx_sequencer #(
  parameter int MAX_HOLD = 47,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    phy_ctl_in,
  output logic [1:0]    ctl_out,
  output logic          ctl_oe,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic [DW-1:0] src_data,
  input  logic          src_valid,
  input  logic          src_last,
  output logic          src_ready,
  input  logic          concat_req,
  input  logic          ms_enable,
  input  logic [1:0]    cur_speed,
  input  logic [1:0]    next_speed,
  output logic          concat_reject,
  output logic          underrun
);
  localparam int CW = $clog2(MAX_HOLD + 1);
  localparam logic [1:0] C_IDLE = 2'b00, C_HOLD = 2'b01, C_TX = 2'b10, C_GRANT = 2'b11;

  typedef enum logic [2:0] {S_WAIT, S_GNT, S_LEAD, S_HOLD, S_SEND, S_TERM, S_TAIL} st_t;
  st_t st, st_nx;

  logic [CW-1:0] hcnt;
  logic          cat_q;
  logic [1:0]    spd_q;

  wire active     = (st == S_LEAD) || (st == S_HOLD) || (st == S_SEND);
  wire fire       = active && src_valid;
  wire bad_spd    = ms_enable && ((next_speed == 2'b11) ||
                                  (next_speed == 2'b00 && cur_speed != 2'b00));
  wire budget_out = (st == S_HOLD) && !src_valid && (hcnt == CW'(MAX_HOLD));

  assign src_ready     = active;
  assign concat_reject = fire && src_last && concat_req && bad_spd;
  assign underrun      = budget_out || ((st == S_SEND) && !src_valid);
  assign ctl_oe        = active || (st == S_TERM) || (st == S_TAIL);
  assign data_oe       = ctl_oe;

  always_comb begin
    if (fire)                                 ctl_out = C_TX;
    else if ((st == S_HOLD) && !budget_out)   ctl_out = C_HOLD;
    else if ((st == S_TERM) && cat_q)         ctl_out = C_HOLD;
    else                                      ctl_out = C_IDLE;
  end

  always_comb begin
    if (fire)                          data_out = src_data;
    else if ((st == S_TERM) && cat_q)  data_out = {spd_q, {(DW-2){1'b0}}};
    else                               data_out = '0;
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_WAIT: if (phy_ctl_in == C_GRANT) st_nx = S_GNT;
      S_GNT:  if (phy_ctl_in == C_IDLE) st_nx = S_LEAD;
              else if (phy_ctl_in != C_GRANT) st_nx = S_WAIT;
      S_LEAD, S_HOLD, S_SEND:
        if (fire)                 st_nx = src_last ? S_TERM : S_SEND;
        else if (st == S_LEAD)    st_nx = S_HOLD;
        else if (st == S_SEND)    st_nx = S_TAIL;
        else if (budget_out)      st_nx = S_TAIL;
      S_TERM: st_nx = S_TAIL;
      default: st_nx = S_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_WAIT;
      hcnt  <= '0;
      cat_q <= 1'b0;
      spd_q <= 2'b00;
    end else begin
      st <= st_nx;
      if (st == S_LEAD)                      hcnt <= '0;
      else if ((st == S_HOLD) && !src_valid) hcnt <= hcnt + 1'b1;
      if (fire && src_last) begin
        cat_q <= concat_req && !bad_spd;
        spd_q <= ms_enable ? next_speed : 2'b00;
      end
    end
  end
endmodule

module phy_tx_sequencer_chk #(
  parameter int MAX_HOLD = 47,
  parameter int DW       = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    phy_ctl_in,
  input logic [1:0]    ctl_out,
  input logic          ctl_oe,
  input logic [DW-1:0] data_out,
  input logic          concat_reject,
  input logic          underrun
);
  localparam int RW = $clog2(MAX_HOLD + 2) + 1;
  logic [RW-1:0] hold_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                             hold_run <= '0;
    else if (ctl_oe && ctl_out == 2'b01)    hold_run <= hold_run + 1'b1;
    else                                    hold_run <= '0;
  end

  assert_handover_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_oe) |-> ($past(phy_ctl_in) == 2'b00 && $past(phy_ctl_in, 2) == 2'b11));

  assert_single_lead_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && $past(ctl_oe) && !$past(ctl_oe, 2) && $past(ctl_out) == 2'b00)
      |-> ctl_out != 2'b00);

  assert_hold_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_run <= RW'(MAX_HOLD));

  assert_tail_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && ctl_out != 2'b10 && $past(ctl_out) == 2'b10)
      |=> (ctl_oe && ctl_out == 2'b00) ##1 !ctl_oe);

  assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_oe |-> (ctl_out == 2'b00 && data_out == '0));

  assert_reject_ends_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    concat_reject |=> (ctl_oe && ctl_out == 2'b00));

  assert_underrun_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (ctl_out == 2'b00) ##1 (ctl_oe && ctl_out == 2'b00) ##1 !ctl_oe);
endmodule

bind phy_tx_sequencer phy_tx_sequencer_chk #(.MAX_HOLD(MAX_HOLD), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phy_ctl_in(phy_ctl_in), .ctl_out(ctl_out),
  .ctl_oe(ctl_oe), .data_out(data_out), .concat_reject(concat_reject),
  .underrun(underrun)
);

// File: tb/phy_tx_sequencer_test.sv
`timescale 1ns/1ps
module phy_tx_sequencer_test;
  localparam int MAXH = 47;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] phy_ctl_in = 2'b00;
  logic [1:0] ctl_out;
  logic       ctl_oe, data_oe, src_ready, concat_reject, underrun;
  logic [7:0] data_out, src_data = 8'h00;
  logic       src_valid = 1'b0, src_last = 1'b0, concat_req = 1'b0, ms_enable = 1'b0;
  logic [1:0] cur_speed = 2'b00, next_speed = 2'b00;

  int vecs = 0, errs = 0;

  always #2 clk = ~clk;

  phy_tx_sequencer uut (
    .clk(clk), .rst_n(rst_n), .phy_ctl_in(phy_ctl_in), .ctl_out(ctl_out),
    .ctl_oe(ctl_oe), .data_out(data_out), .data_oe(data_oe),
    .src_data(src_data), .src_valid(src_valid), .src_last(src_last),
    .src_ready(src_ready), .concat_req(concat_req), .ms_enable(ms_enable),
    .cur_speed(cur_speed), .next_speed(next_speed),
    .concat_reject(concat_reject), .underrun(underrun)
  );

  function automatic bit bad_pair(bit ms, bit [1:0] cs, bit [1:0] ns);
    return ms && (ns == 2'b11 || (ns == 2'b00 && cs != 2'b00));
  endfunction

  function automatic logic [14:0] pack(bit oe, bit rdy, bit [1:0] c, bit [7:0] d, bit ur, bit rj);
    return {oe, oe, rdy, c, d, ur, rj};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_bus(string req, bit oe, bit rdy, bit [1:0] c, bit [7:0] d, bit ur, bit rj);
    logic [14:0] act, exp;
    @(negedge clk);
    act = {ctl_oe, data_oe, src_ready, ctl_out, data_out, underrun, concat_reject};
    exp = pack(oe, rdy, c, d, ur, rj);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tail_release(string req);
    step(); src_valid = 1'b0; src_last = 1'b0;
    expect_bus({req, "/R6 tail"}, 1, 0, 2'b00, 8'h00, 0, 0);
    step();
    expect_bus({req, "/R6 release"}, 0, 0, 2'b00, 8'h00, 0, 0);
  endtask

  task automatic xfer(int wn, int len, bit cat, bit [1:0] cs, bit [1:0] ns, bit ms, int gap);
    bit bad, eff;
    bit [7:0] b;
    bad = bad_pair(ms, cs, ns);
    eff = cat && !bad;
    concat_req = cat; cur_speed = cs; next_speed = ns; ms_enable = ms;
    step(); phy_ctl_in = 2'b11;
    expect_bus("R1 grant seen", 0, 0, 2'b00, 8'h00, 0, 0);
    step(); phy_ctl_in = 2'b00;
    expect_bus("R1 grant idle", 0, 0, 2'b00, 8'h00, 0, 0);
    if (wn > 0) begin
      step(); src_valid = 1'b0;
      expect_bus("R2 lead idle", 1, 1, 2'b00, 8'h00, 0, 0);
      for (int k = 1; k < wn; k++) begin
        step();
        if (k <= MAXH) expect_bus("R3 hold", 1, 1, 2'b01, 8'h00, 0, 0);
        else begin
          expect_bus("R9 abandon", 1, 1, 2'b00, 8'h00, 1, 0);
          tail_release("R9");
          return;
        end
      end
    end
    for (int i = 0; i < len; i++) begin
      step();
      if (i == gap && i > 0) begin
        src_valid = 1'b0;
        expect_bus("R10 gap", 1, 1, 2'b00, 8'h00, 1, 0);
        tail_release("R10");
        return;
      end
      b = 8'($urandom);
      src_valid = 1'b1; src_data = b; src_last = (i == len - 1);
      expect_bus("R4 transmit", 1, 1, 2'b10, b, 0, (i == len - 1) && cat && bad);
    end
    step(); src_valid = 1'b0; src_last = 1'b0;
    if (eff) expect_bus("R5 R7 hold end", 1, 0, 2'b01, {(ms ? ns : 2'b00), 6'b0}, 0, 0);
    else     expect_bus("R5 R8 idle end", 1, 0, 2'b00, 8'h00, 0, 0);
    tail_release("R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    expect_bus("R11 in reset", 0, 0, 2'b00, 8'h00, 0, 0);
    step(); rst_n = 1'b1;
    expect_bus("R11 after reset", 0, 0, 2'b00, 8'h00, 0, 0);

    // R1: grant followed by status is not a handover
    step(); phy_ctl_in = 2'b11;
    expect_bus("R1 false grant", 0, 0, 2'b00, 8'h00, 0, 0);
    step(); phy_ctl_in = 2'b01;
    expect_bus("R1 false grant", 0, 0, 2'b00, 8'h00, 0, 0);
    step(); phy_ctl_in = 2'b00;
    expect_bus("R1 no takeover", 0, 0, 2'b00, 8'h00, 0, 0);
    step();
    expect_bus("R1 no takeover", 0, 0, 2'b00, 8'h00, 0, 0);

    xfer(0, 1, 0, 2'b00, 2'b00, 0, -1);
    xfer(1, 3, 0, 2'b01, 2'b00, 0, -1);
    xfer(48, 2, 0, 2'b00, 2'b00, 0, -1);          // R3 exactly 47 holds
    xfer(49, 2, 0, 2'b00, 2'b00, 0, -1);          // R9 budget exhausted
    xfer(0, 4, 1, 2'b10, 2'b01, 1, -1);           // R7 speed code
    xfer(2, 2, 1, 2'b01, 2'b10, 0, -1);           // R7 no ms: zero data
    xfer(0, 2, 1, 2'b10, 2'b00, 1, -1);           // R8 S100 after S400
    xfer(0, 1, 1, 2'b01, 2'b11, 1, -1);           // R8 reserved code
    xfer(0, 3, 1, 2'b00, 2'b00, 1, -1);           // R8 S100 after S100 legal
    xfer(0, 5, 0, 2'b00, 2'b00, 0, 2);            // R10 gap

    for (int t = 0; t < 60; t++) begin
      int ln, gp;
      ln = $urandom_range(1, 6);
      gp = (ln > 1 && $urandom_range(0, 7) == 0) ? $urandom_range(1, ln - 1) : -1;
      xfer($urandom_range(0, 4), ln, 1'($urandom), 2'($urandom_range(0, 2)),
           2'($urandom), 1'($urandom), gp);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule